// File: doc/BRIEF.md
# Stream Identifier Span Filter

This block decides, for every transaction seen by a bank of event counters, which of those counters may count it. Each transaction arrives as a one-cycle valid strobe carrying a 32-bit stream identifier. Every counter has a filter enable, a span flag and a 32-bit pattern. The block answers with one match bit per counter, registered one cycle after the strobe.

With the span flag clear, the identifier must equal the pattern in every bit. With the span flag set, the pattern also describes which low bits are don't-care. The run of ones at the bottom of the pattern, together with the first zero above that run, marks the low identifier bits that are ignored. Every bit above that zero must equal the pattern. No separate mask register exists. For example, pattern 0x42 with span set has its lowest zero at bit 0, so it accepts exactly 0x42 and 0x43.

A global mode makes counter 0's enable, span and pattern the one filter for all counters. In this mode the settings of the other counters are ignored. Event counting and register access live outside this block.

Top module: `sid_span_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every match output is 0.
- R2: Each match bit is registered. It reflects the transaction strobed on the previous clock edge, and it is 0 in any cycle whose previous edge saw no valid strobe.
- R3: With the filter enabled and span clear, a counter matches only when all 32 identifier bits equal its pattern.
- R4: With span set, let Z be the position of the lowest zero bit in the pattern. Identifier bits 0..Z are ignored, and bits Z+1..31 must equal the pattern. Pattern 0x42 accepts 0x42 and 0x43 and rejects 0x40 and 0x44.
- R5: With span set and a pattern of all ones, every identifier matches.
- R6: A counter whose filter enable is 0 matches every identifier, whatever its pattern and span.
- R7: When global mode is 1, every counter uses counter 0's enable, span and pattern. The settings of counters 1 and up have no effect, so all match bits are equal.
- R8: When global mode is 0, each counter is judged only against its own enable, span and pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | Transaction strobe, one cycle per transaction |
| txn_sid | input | 32 | Stream identifier of the transaction |
| flt_enable | input | NUM_CTR | Per-counter filter enable; 0 means pass everything |
| flt_span | input | NUM_CTR | Per-counter span flag; 1 means the pattern encodes don't-care low bits |
| flt_pattern | input | NUM_CTR*32 | Per-counter patterns; counter k uses bits 32k+31..32k |
| global_mode | input | 1 | 1 means counter 0's filter applies to all counters |
| match | output | NUM_CTR | Per-counter match, one cycle after the strobe |

## Verification
The exact-match test uses a pattern and identifiers that differ only in bit 0 or only in bit 31. This shows whether both ends of the word take part in the comparison. The span tests use 0x42 (terminating zero at bit 0) and 0xF7 (three trailing ones, terminating zero at bit 3), with identifiers just inside and just outside each ignored range. These tell a correct mask apart from one that is off by one bit or that leaves out the terminating zero. An all-ones pattern, a disabled filter and a global-mode run with conflicting settings on counters 1 to 3 show that the all-ones case, the bypass path and the counter 0 broadcast are separate. A mixed run with four different per-counter settings shows that the lanes do not leak into each other.

// File: rtl/sidf_pkg.sv
package sidf_pkg;

  localparam int SID_BITS = 32;

  typedef logic [SID_BITS-1:0] sid_t;

  typedef struct packed {
    sid_t pattern;
    logic span;
    logic enable;
  } flt_cfg_t;

  // Don't-care bits: the trailing ones of the pattern plus the first zero.
  // Adding one flips exactly those bits, so XOR with the sum isolates them.
  function automatic sid_t ignore_mask(input sid_t pat, input logic span);
    sid_t inc;
    inc = pat + sid_t'(1);
    return span ? (pat ^ inc) : '0;
  endfunction

  function automatic logic sid_hit(input sid_t sid, input sid_t pat, input sid_t ign);
    return ((sid ^ pat) & ~ign) == '0;
  endfunction

endpackage

// File: rtl/sidf_cfg_select.sv
module sidf_cfg_select
  import sidf_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic                     global_mode,
  input  flt_cfg_t [NUM_CTR-1:0]   cfg_in,
  output flt_cfg_t [NUM_CTR-1:0]   cfg_eff
);

  // Global mode broadcasts lane 0's settings to every lane.
  for (genvar k = 0; k < NUM_CTR; k++) begin : g_sel
    if (k == 0) begin : g_lead
      assign cfg_eff[k] = cfg_in[0];
    end else begin : g_follow
      assign cfg_eff[k] = global_mode ? cfg_in[0] : cfg_in[k];
    end
  end

endmodule

// File: rtl/sidf_lane.sv
module sidf_lane
  import sidf_pkg::*;
(
  input  flt_cfg_t cfg,
  input  sid_t     sid,
  output logic     hit
);

  sid_t ign;

  always_comb begin
    ign = ignore_mask(cfg.pattern, cfg.span);
    hit = !cfg.enable || sid_hit(sid, cfg.pattern, ign);
  end

endmodule

// File: rtl/sid_span_filter.sv
module sid_span_filter
  import sidf_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          txn_valid,
  input  logic [SID_BITS-1:0]           txn_sid,
  input  logic [NUM_CTR-1:0]            flt_enable,
  input  logic [NUM_CTR-1:0]            flt_span,
  input  logic [NUM_CTR*SID_BITS-1:0]   flt_pattern,
  input  logic                          global_mode,
  output logic [NUM_CTR-1:0]            match
);

  flt_cfg_t [NUM_CTR-1:0] cfg_raw;
  flt_cfg_t [NUM_CTR-1:0] cfg_eff;
  logic     [NUM_CTR-1:0] lane_hit;

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_lane
    assign cfg_raw[k].pattern = flt_pattern[k*SID_BITS +: SID_BITS];
    assign cfg_raw[k].span    = flt_span[k];
    assign cfg_raw[k].enable  = flt_enable[k];

    sidf_lane u_lane (
      .cfg (cfg_eff[k]),
      .sid (txn_sid),
      .hit (lane_hit[k])
    );
  end

  sidf_cfg_select #(.NUM_CTR(NUM_CTR)) u_sel (
    .global_mode (global_mode),
    .cfg_in      (cfg_raw),
    .cfg_eff     (cfg_eff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) match <= '0;
    else        match <= txn_valid ? lane_hit : '0;
  end

endmodule

// File: rtl/sidf_checker.sv
module sidf_checker
  import sidf_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        txn_valid,
  input logic [SID_BITS-1:0]         txn_sid,
  input logic [NUM_CTR-1:0]          flt_enable,
  input logic [NUM_CTR-1:0]          flt_span,
  input logic [NUM_CTR*SID_BITS-1:0] flt_pattern,
  input logic                        global_mode,
  input logic [NUM_CTR-1:0]          match,
  input logic [NUM_CTR-1:0]          lane_hit
);

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> match == '0);

  assert_reg_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> match == $past(lane_hit));

  assert_exact_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !global_mode && flt_enable[0] && !flt_span[0] &&
    txn_sid == flt_pattern[SID_BITS-1:0] |=> match[0]);

  assert_exact_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !global_mode && flt_enable[0] && !flt_span[0] &&
    txn_sid != flt_pattern[SID_BITS-1:0] |=> !match[0]);

  assert_bit0_dontcare_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !global_mode && flt_enable[0] && flt_span[0] &&
    !flt_pattern[0] && txn_sid[SID_BITS-1:1] == flt_pattern[SID_BITS-1:1] |=> match[0]);

  assert_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !global_mode && flt_enable[0] && flt_span[0] &&
    (&flt_pattern[SID_BITS-1:0]) |=> match[0]);

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !global_mode |=> (~$past(flt_enable) & ~match) == '0);

  assert_uniform_R7: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && global_mode |=> (match == '0) || (&match));

endmodule

bind sid_span_filter sidf_checker #(.NUM_CTR(NUM_CTR)) u_chk (.*);

// File: tb/tb_sid_span_filter.sv
module tb_sid_span_filter;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            txn_valid = 1'b0;
  logic [31:0]     txn_sid = '0;
  logic [N-1:0]    en = '0;
  logic [N-1:0]    span = '0;
  logic [31:0]     pat [N];
  logic            glob = 1'b0;
  logic [N*32-1:0] pat_flat;
  logic [N-1:0]    match;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) pat_flat[k*32 +: 32] = pat[k];
  end

  sid_span_filter #(.NUM_CTR(N)) dut (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_sid(txn_sid),
    .flt_enable(en), .flt_span(span), .flt_pattern(pat_flat),
    .global_mode(glob), .match(match)
  );

  // Reference: search for the lowest zero, then compare every bit above it.
  function automatic logic model_hit(logic [31:0] sid, logic [31:0] p, logic s, logic e);
    int z;
    bit found;
    if (!e) return 1'b1;
    if (!s) return sid == p;
    found = 0;
    z = 32;
    for (int i = 0; i < 32; i++) if (!found && !p[i]) begin z = i; found = 1; end
    for (int b = z + 1; b < 32; b++) if (sid[b] != p[b]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [N-1:0] model_vec(logic [31:0] sid);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) begin
      int src;
      src = glob ? 0 : k;
      v[k] = model_hit(sid, pat[src], span[src], en[src]);
    end
    return v;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive on a falling edge, let one rising edge register, sample on the next falling edge.
  task automatic send(logic [31:0] sid, string tag);
    logic [N-1:0] exp;
    @(negedge clk);
    txn_sid = sid;
    txn_valid = 1'b1;
    exp = model_vec(sid);
    @(negedge clk);
    txn_valid = 1'b0;
    check(tag, match, exp);
  endtask

  task automatic send_expect(logic [31:0] sid, logic [N-1:0] exp, string tag);
    @(negedge clk);
    txn_sid = sid;
    txn_valid = 1'b1;
    @(negedge clk);
    txn_valid = 1'b0;
    check(tag, match, exp);
  endtask

  task automatic set_all(logic e, logic s, logic [31:0] p);
    for (int k = 0; k < N; k++) begin en[k] = e; span[k] = s; pat[k] = p; end
  endtask

  task automatic t_reset();
    set_all(1'b0, 1'b0, 32'h0);
    txn_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", match, '0);
    rst_n = 1'b1;
    txn_valid = 1'b0;
    @(negedge clk);
    check("R1 after reset", match, '0);
  endtask

  task automatic t_idle();
    set_all(1'b0, 1'b0, 32'h0);
    @(negedge clk);
    txn_valid = 1'b0;
    @(negedge clk);
    check("R2 no strobe", match, '0);
    send_expect(32'h1, '1, "R2 strobe registered");
    @(negedge clk);
    check("R2 strobe gone", match, '0);
  endtask

  task automatic t_exact();
    set_all(1'b1, 1'b0, 32'h1234_5678);
    send_expect(32'h1234_5678, '1, "R3 equal");
    send_expect(32'h1234_5679, '0, "R3 bit0 differs");
    send_expect(32'h9234_5678, '0, "R3 bit31 differs");
  endtask

  task automatic t_span();
    set_all(1'b1, 1'b1, 32'h42);
    send_expect(32'h42, '1, "R4 0x42");
    send_expect(32'h43, '1, "R4 0x43");
    send_expect(32'h40, '0, "R4 0x40");
    send_expect(32'h44, '0, "R4 0x44");
    set_all(1'b1, 1'b1, 32'hF7);
    send_expect(32'hF0, '1, "R4 0xF7 low end");
    send_expect(32'hFF, '1, "R4 0xF7 high end");
    send_expect(32'hE8, '0, "R4 0xF7 bit4 differs");
    send_expect(32'h1F8, '0, "R4 0xF7 bit8 differs");
    for (int i = 0; i < 40; i++) send(32'hE0 + 32'(i * 7), "R4 sweep");
  endtask

  task automatic t_all_ones();
    set_all(1'b1, 1'b1, 32'hFFFF_FFFF);
    send_expect(32'h0, '1, "R5 zero id");
    send_expect(32'hDEAD_BEEF, '1, "R5 arbitrary id");
  endtask

  task automatic t_disabled();
    set_all(1'b0, 1'b0, 32'h5);
    send_expect(32'h99, '1, "R6 span clear");
    set_all(1'b0, 1'b1, 32'h42);
    send_expect(32'h7000_0000, '1, "R6 span set");
  endtask

  task automatic t_global();
    en = 4'b1111;
    span = 4'b0011;
    pat[0] = 32'h42; pat[1] = 32'h50; pat[2] = 32'h43; pat[3] = 32'hFFFF_FFFF;
    glob = 1'b1;
    send_expect(32'h43, 4'b1111, "R7 lane0 hit broadcast");
    send_expect(32'h50, 4'b0000, "R7 lane0 miss broadcast");
    en = 4'b1110;
    send_expect(32'h1234, 4'b1111, "R7 lane0 disabled broadcast");
    glob = 1'b0;
  endtask

  task automatic t_independent();
    en = 4'b1011;
    span = 4'b0101;
    pat[0] = 32'h42; pat[1] = 32'h43; pat[2] = 32'h0; pat[3] = 32'h40;
    send_expect(32'h43, 4'b0111, "R8 mixed 0x43");
    send_expect(32'h40, 4'b1100, "R8 mixed 0x40");
    send_expect(32'h42, 4'b0101, "R8 mixed 0x42");
    for (int i = 0; i < 16; i++) send(32'h3C + 32'(i), "R8 sweep");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_exact();
    t_span();
    t_all_ones();
    t_disabled();
    t_global();
    t_independent();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule